// File: doc/BRIEF.md
# SPI Flash Programmable Command Shifter

This block is a single-lane SPI master for serial NOR flash. It runs one generic command transaction. Software sets up the transaction through a small byte-wide register port. It loads up to six transmit bytes, with the opcode in the top slot and any address or argument bytes in the slots below it. It then writes a bit count and sets an execute bit. The engine pulls chip select low and toggles the serial clock for the programmed number of bits. It sends the transmit bytes most significant bit first. At the same time it shifts every sampled input bit into a 56-bit receive register.

When the last bit has been clocked, the engine releases chip select, clears busy and raises done. Software then reads the captured bytes back. The receive path is a plain shift register, so the first byte the flash returns sits at the highest populated byte index. The byte clocked in while the opcode goes out carries no valid data.

Top module: `spi_cmd_shifter`

## Requirements
- R1: After reset, chip select is high, the serial clock and MOSI are low, and every readable register returns 0 (status bit 0 = busy, bit 1 = done).
- R2: Register map on the 4-bit address: 0..5 are transmit slots (slot 5 holds the opcode), 6 is the bit count, 7 is control/status (write bit 0 = execute; read bit 0 = busy, bit 1 = done), and 8..14 are receive bytes 0..6, where receive byte k is bits 8k+7..8k of the receive register. Address 15 reads 0.
- R3: A bit count above 56 is stored, and reads back, as 56.
- R4: An execute with a nonzero count sets busy and clears done. Done is raised CLK_DIV*count+1 system cycles after the cycle that accepted the execute, and exactly count serial clock pulses occur.
- R5: MOSI carries bit 7 of slot 5 first, then continues MSB-first through slots 5, 4, 3, 2, 1 and 0. Any bits beyond those 48 are 0.
- R6: The serial clock uses SPI mode 0. It idles low, pulses only while chip select is low, and MOSI holds steady while the clock is high. Chip select falls one system cycle before the first rising clock edge and rises CLK_DIV/2 system cycles after the last falling edge.
- R7: The receive register is cleared at execute. On each rising serial clock edge MISO enters bit 0 and the older bits move up one place. After 8N bits, the first returned byte is at receive byte N-1 and the last at byte 0.
- R8: An execute with a count of 0 raises done on the next cycle, leaves busy low and produces no chip select activity.
- R9: While busy, writes to the transmit slots, the count and the execute bit have no effect.
- R10: Done stays set until the next accepted execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from reg_addr) |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
A wrong transmit shift state shows up on MOSI at the first wrong bit. A wrong receive state shows up only at readback after done, possibly as a byte landing in a neighbouring index. An error in the phase or bit counter changes the number of clock pulses and the cycle in which done rises, so each transaction checks the exact done cycle and the edge positions of chip select. Random counts and data are mixed with directed cases for count 0, a single bit, the full 56-bit window, an oversize count and writes made while busy.

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter #(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [3:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       spi_cs_n,
  output logic       spi_sclk,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  localparam int TX_BYTES = 6;
  localparam int RX_BYTES = 7;
  localparam int WIN_BITS = RX_BYTES * 8;
  localparam int HALF     = CLK_DIV / 2;
  localparam int HW       = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BW       = $clog2(WIN_BITS + 1);
  localparam logic [HW-1:0] PH_TOP = HW'(HALF - 1);
  localparam logic [3:0] A_CNT = 4'd6;
  localparam logic [3:0] A_CTL = 4'd7;
  localparam logic [3:0] A_RX0 = 4'd8;

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_HIGH, S_LOW, S_TRAIL} st_t;

  st_t                 st;
  logic [7:0]          txd [TX_BYTES];
  logic [BW-1:0]       cnt, left;
  logic [HW-1:0]       ph;
  logic [WIN_BITS-1:0] tx_sh, rx_sh, tx_init;
  logic                busy, done;

  wire wr_slot = reg_we && !busy && (reg_addr < 4'(TX_BYTES));
  wire wr_cnt  = reg_we && !busy && (reg_addr == A_CNT);
  wire go      = reg_we && !busy && (reg_addr == A_CTL) && reg_wdata[0];
  wire [BW-1:0] cnt_in = (reg_wdata > 8'(WIN_BITS)) ? BW'(WIN_BITS) : reg_wdata[BW-1:0];
  wire [3:0] rx_idx = reg_addr - A_RX0;

  always_comb begin
    tx_init = '0;
    for (int i = 0; i < TX_BYTES; i++) tx_init[8*(i+1) +: 8] = txd[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TX_BYTES; i++) txd[i] <= '0;
      cnt <= '0;
    end else begin
      if (wr_slot) txd[reg_addr[2:0]] <= reg_wdata;
      if (wr_cnt)  cnt <= cnt_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; spi_cs_n <= 1'b1; spi_sclk <= 1'b0;
      busy <= 1'b0; done <= 1'b0;
      tx_sh <= '0; rx_sh <= '0; left <= '0; ph <= '0;
    end else begin
      case (st)
        S_IDLE: if (go) begin
          done <= (cnt == '0);
          if (cnt != '0) begin
            busy <= 1'b1; spi_cs_n <= 1'b0;
            tx_sh <= tx_init; rx_sh <= '0; left <= cnt;
            st <= S_LEAD;
          end
        end
        S_LEAD: begin
          spi_sclk <= 1'b1;
          rx_sh <= {rx_sh[WIN_BITS-2:0], spi_miso};
          ph <= PH_TOP;
          st <= S_HIGH;
        end
        S_HIGH: if (ph != '0) ph <= ph - 1'b1;
        else begin
          spi_sclk <= 1'b0;
          ph <= PH_TOP;
          left <= left - 1'b1;
          if (left == BW'(1)) st <= S_TRAIL;
          else begin
            tx_sh <= tx_sh << 1;
            st <= S_LOW;
          end
        end
        S_LOW: if (ph != '0) ph <= ph - 1'b1;
        else begin
          spi_sclk <= 1'b1;
          rx_sh <= {rx_sh[WIN_BITS-2:0], spi_miso};
          ph <= PH_TOP;
          st <= S_HIGH;
        end
        S_TRAIL: if (ph != '0) ph <= ph - 1'b1;
        else begin
          spi_cs_n <= 1'b1; busy <= 1'b0; done <= 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign spi_mosi = !spi_cs_n && tx_sh[WIN_BITS-1];

  always_comb begin
    reg_rdata = '0;
    if (reg_addr < 4'(TX_BYTES))      reg_rdata = txd[reg_addr[2:0]];
    else if (reg_addr == A_CNT)       reg_rdata = 8'(cnt);
    else if (reg_addr == A_CTL)       reg_rdata = {6'b0, done, busy};
    else if (rx_idx < 4'(RX_BYTES))   reg_rdata = rx_sh[{rx_idx[2:0], 3'b000} +: 8];
  end

  // R6
  sclk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> !spi_cs_n);
  // R6
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));
  // R4
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !go) |=> done);
  // R8
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && cnt == '0) |=> (done && !busy && spi_cs_n));
  // R9
  busy_cnt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we && reg_addr == A_CNT) |=> $stable(cnt));
  // R3
  cnt_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= BW'(WIN_BITS));
endmodule

// File: tb/spi_cmd_shifter_tb.sv
module spi_cmd_shifter_tb_top;
  localparam int DIV = 4;
  localparam int HALF = DIV / 2;

  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0, spi_miso = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic spi_cs_n, spi_sclk, spi_mosi;

  spi_cmd_shifter #(.CLK_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_cs_n(spi_cs_n),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [55:0] pat = '0, cap = '0;
  int idx = 0, rises = 0, cs_falls = 0, mosi_viol = 0;
  bit first = 0;
  time t_csf = 0, t_rise0 = 0, t_lastfall = 0, t_csr = 0;
  logic prev_sclk = 0, prev_mosi = 0;

  always @(negedge spi_cs_n) begin
    idx = 0; rises = 0; cap = '0; first = 1; t_csf = $time;
    cs_falls++;
    spi_miso <= pat[55];
  end
  always @(posedge spi_sclk) begin
    if (first) t_rise0 = $time;
    first = 0;
    cap = {cap[54:0], spi_mosi};
    idx++; rises++;
  end
  always @(negedge spi_sclk) begin
    t_lastfall = $time;
    if (idx < 56) spi_miso <= pat[55 - idx];
  end
  always @(posedge spi_cs_n) t_csr = $time;
  always @(negedge clk) begin
    if (spi_sclk && prev_sclk && spi_mosi !== prev_mosi) mosi_viol++;
    prev_sclk = spi_sclk; prev_mosi = spi_mosi;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  function automatic logic [55:0] tail(input logic [55:0] v, input int n);
    return (n == 0) ? 56'h0 : (v >> (56 - n));
  endfunction

  task automatic run(input int n_in, input logic [47:0] d, input logic [55:0] p, input bit inject);
    int n, k, falls0;
    logic [7:0] b;
    logic [55:0] got;
    time t_e;
    n = (n_in > 56) ? 56 : n_in;
    pat = p;
    for (int i = 0; i < 6; i++) wr(4'(i), d[8*i +: 8]);
    wr(4'd6, 8'(n_in));
    rd(4'd6, b);
    check(b == 8'(n), "R3 count readback", b, n);
    falls0 = cs_falls;
    wr(4'd7, 8'h01);
    t_e = $time;
    if (inject) begin
      wr(4'd5, 8'hFF); wr(4'd6, 8'd3); wr(4'd7, 8'h01);
    end
    k = 0;
    do begin
      rd(4'd7, b); k++;
    end while (!b[1] && k < 2000);
    k = int'(($time - 1 - t_e) / 4);
    check(k == n * DIV + 1, "R4 done cycle", k, n * DIV + 1);
    check(b == 8'h02, "R4 status after done", b, 8'h02);
    if (n == 0) begin
      check(cs_falls == falls0, "R8 no chip select activity", cs_falls, falls0);
    end else begin
      check(rises == n, "R4 clock pulses", rises, n);
      check(cap[55:0] == tail({d, 8'h00}, n), "R5 MOSI stream", cap, tail({d, 8'h00}, n));
      check(t_rise0 - t_csf == 4, "R6 lead time", t_rise0 - t_csf, 4);
      check(t_csr - t_lastfall == HALF * 4, "R6 trail time", t_csr - t_lastfall, HALF * 4);
      check(mosi_viol == 0, "R6 MOSI stable while high", mosi_viol, 0);
      got = '0;
      for (int i = 0; i < 7; i++) begin
        rd(4'(8 + i), b);
        got[8*i +: 8] = b;
      end
      check(got == tail(p, n), "R7 receive bytes", got, tail(p, n));
    end
    if (inject) begin
      rd(4'd5, b);
      check(b == d[47:40], "R9 slot write while busy", b, d[47:40]);
      rd(4'd6, b);
      check(b == 8'(n), "R9 count write while busy", b, n);
    end
    repeat (3) @(negedge clk);
    rd(4'd7, b);
    check(b == 8'h02, "R10 done held", b, 8'h02);
  endtask

  initial begin
    #600000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] b;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(spi_cs_n == 1'b1 && spi_sclk == 1'b0 && spi_mosi == 1'b0, "R1 pins at reset",
          {spi_cs_n, spi_sclk, spi_mosi}, 3'b100);
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), b);
      check(b == 8'h00, "R1 register reset value", b, 0);
    end
    for (int a = 0; a < 6; a++) begin
      wr(4'(a), 8'(8'h30 + a));
      rd(4'(a), b);
      check(b == 8'(8'h30 + a), "R2 slot readback", b, 8'h30 + a);
    end
    rd(4'd15, b);
    check(b == 8'h00, "R2 unused address", b, 0);

    // R7 byte placement: first returned byte at index N-1
    run(24, 48'h9F0000000000, 56'hA1B2C3_00000000, 0);
    rd(4'd10, b); check(b == 8'hA1, "R7 first byte at index 2", b, 8'hA1);
    rd(4'd8, b);  check(b == 8'hC3, "R7 last byte at index 0", b, 8'hC3);
    run(0, 48'h050000000000, 56'h0, 0);                           // R8
    run(1, 48'h800000000000, 56'h80000000000000, 0);
    run(56, 48'h0B123456789A, 56'h0123456789ABCD, 0);            // R5 zero fill
    run(60, 48'hFFFFFFFFFFFF, 56'hFEDCBA98765432, 0);            // R3 clamp
    run(16, 48'h03AABBCCDDEE, 56'h5A5A0000000000, 1);            // R9
    for (int t = 0; t < 20; t++)
      run(int'($urandom_range(1, 56)), {$urandom, 16'($urandom)},
          {$urandom, 24'($urandom)}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule